// File: doc/BRIEF.md
# Framed Packet Builder With Checksum

This block turns a short command message into a framed byte stream for a shared buffer memory. Parameter bytes arrive on a valid/ready byte input and are held inside the block. The command byte, the destination address and the framing options arrive as sideband inputs. When the last parameter byte is accepted, the block emits the frame one byte at a time on a valid/ready output. Each frame can carry an optional start marker, an optional destination address, a length byte, the command, the parameters, a check byte and an optional end marker.

The length byte is known before the first output byte, because the whole payload is buffered first. It counts every byte of the frame, including the optional fields. The check byte protects the frame body. It can be computed in one of three ways, chosen per frame. A one-cycle done pulse tells the memory write side that the frame is complete. After that pulse the block accepts the next payload.

Top module: `pkt_framer`

## Requirements
- R1: Fields leave in this fixed order: start marker, address, length, command, parameter bytes in arrival order, check byte, end marker. Each byte is emitted only when its field is enabled.
- R2: When `cfg_hdr_en` is 1 the frame begins with the start marker 0xA5. When it is 0 no start marker is sent.
- R3: When `cfg_addr_en` is 1 the byte on `dst_addr` follows the start marker. When it is 0 no address byte is sent.
- R4: When `cfg_trl_en` is 1 the frame ends with the end marker 0x5A after the check byte. When it is 0 the check byte is the last byte.
- R5: The length byte equals the total number of bytes in the frame: payload count + 3 + one for each enabled optional field.
- R6: The check byte covers the address byte (if present), the length byte, the command byte and every parameter byte. `cfg_chk_mode` selects the method: 0 = low 8 bits of the sum, 1 = XOR of the bytes, 2 = CRC-8 with polynomial 0x07, initial value 0x00, no reflection, MSB first, 3 = same as 0.
- R7: Up to 32 parameter bytes are held. The 32nd accepted byte ends the payload even if `in_last` is 0, and the frame then starts.
- R8: A payload ends when a byte with `in_last` = 1 is accepted. From then until the frame is complete, `in_ready` is 0, so no input byte is taken while a frame is being emitted.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_valid` keep their values into the next cycle.
- R10: `done` is 1 for exactly one cycle, in the cycle right after the final frame byte is accepted. In that same cycle `in_ready` is 1 again.
- R11: The options, `cmd_byte` and `dst_addr` are sampled when the final payload byte is accepted. Later changes to them do not affect the frame being emitted.
- R12: After reset, `out_valid` = 0, `done` = 0 and `in_ready` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_hdr_en | input | 1 | Include the start marker |
| cfg_addr_en | input | 1 | Include the destination address |
| cfg_trl_en | input | 1 | Include the end marker |
| cfg_chk_mode | input | 2 | Check method selection |
| cmd_byte | input | 8 | Command byte of the frame |
| dst_addr | input | 8 | Destination address byte |
| in_valid | input | 1 | Parameter byte valid |
| in_data | input | 8 | Parameter byte |
| in_last | input | 1 | Marks the final parameter byte |
| in_ready | output | 1 | Block accepts a parameter byte |
| out_valid | output | 1 | Frame byte valid |
| out_data | output | 8 | Frame byte |
| out_ready | input | 1 | Consumer accepts the frame byte |
| done | output | 1 | One-cycle pulse after the final frame byte |

## Verification
The assertions assume that reset is applied before the first frame. They also assume that the payload depth parameter leaves room for the length byte to fit in eight bits. They place no limit on how `out_ready` toggles, so the stall checks hold under any consumer pattern. The stimulus holds `in_valid` low while a frame is being emitted. It drives `out_ready` both steadily high and in a pattern with regular stalls. It deliberately changes the sideband inputs once a payload has closed, to show that those changes have no effect on the frame.

// File: rtl/pkt_framer_pkg.sv
// Shared types for the packet framer: check-method codes, frame field
// states and the CRC-8 step used by the check unit.
package pkt_framer_pkg;

    typedef enum logic [1:0] {
        CHK_SUM     = 2'd0,
        CHK_XOR     = 2'd1,
        CHK_CRC     = 2'd2,
        CHK_SUM_ALT = 2'd3
    } chk_mode_e;

    typedef enum logic [2:0] {
        ST_LOAD = 3'd0,
        ST_HDR  = 3'd1,
        ST_ADDR = 3'd2,
        ST_LEN  = 3'd3,
        ST_CMD  = 3'd4,
        ST_PAY  = 3'd5,
        ST_CHK  = 3'd6,
        ST_TRL  = 3'd7
    } fld_e;

    // One byte through an MSB-first, non-reflected CRC-8.
    function automatic logic [7:0] crc8_step(input logic [7:0] crc,
                                             input logic [7:0] data,
                                             input logic [7:0] poly);
        logic [7:0] c;
        c = crc ^ data;
        for (int b = 0; b < 8; b++) begin
            c = c[7] ? ((c << 1) ^ poly) : (c << 1);
        end
        return c;
    endfunction

endpackage

// File: rtl/pkt_payload_buf.sv
// Payload store for the packet framer.
// Holds up to DEPTH bytes written in order from index 0. Assumes the writer
// never writes while full and that reads only use indices below count.
// A clear empties the store for the next frame.
module pkt_payload_buf #(
    parameter int DEPTH = 32,
    parameter int W     = 8,
    localparam int IW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr_en,
    input  logic [W-1:0]  wr_data,
    input  logic [IW-1:0] rd_idx,
    output logic [W-1:0]  rd_data,
    output logic [CW-1:0] count,
    output logic          full
);

    logic [W-1:0] mem [DEPTH];

    // Store an accepted byte at the next free slot.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[count[IW-1:0]] <= wr_data;
        end
    end

    // Track how many bytes are held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (wr_en) begin
            count <= count + CW'(1);
        end
    end

    assign rd_data = mem[rd_idx];
    assign full    = (count == CW'(DEPTH));

    // R7
    no_overfill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !full);

    // R7
    depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

endmodule

// File: rtl/pkt_check_unit.sv
// Running check value for the framer.
// Folds one byte per enable into an accumulator using the selected method
// (sum, XOR or CRC-8). Assumes clear and enable are never asserted together.
module pkt_check_unit
    import pkt_framer_pkg::*;
#(
    parameter logic [7:0] POLY = 8'h07
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       en,
    input  chk_mode_e  mode,
    input  logic [7:0] din,
    output logic [7:0] acc
);

    logic [7:0] acc_nxt;

    // Next accumulator value for the selected method.
    always_comb begin
        case (mode)
            CHK_XOR: acc_nxt = acc ^ din;
            CHK_CRC: acc_nxt = crc8_step(acc, din, POLY);
            default: acc_nxt = acc + din;
        endcase
    end

    // Hold the running value; a clear restarts it at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (clr) begin
            acc <= '0;
        end else if (en) begin
            acc <= acc_nxt;
        end
    end

    // R6
    clr_en_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(clr && en));

    // R6
    zero_byte_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && din == 8'h00 && mode != CHK_CRC) |=> $stable(acc));

endmodule

// File: rtl/pkt_framer.sv
// Packet framer top.
// Collects a payload of up to DEPTH bytes, then emits a frame with optional
// start marker, optional address, length, command, payload, check byte
// and optional end marker. Assumes DEPTH + 6 fits in one length byte.
// Sideband options are latched when the payload closes.
module pkt_framer
    import pkt_framer_pkg::*;
#(
    parameter int         DEPTH      = 32,
    parameter logic [7:0] START_MARK = 8'hA5,
    parameter logic [7:0] END_MARK   = 8'h5A
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_hdr_en,
    input  logic       cfg_addr_en,
    input  logic       cfg_trl_en,
    input  logic [1:0] cfg_chk_mode,
    input  logic [7:0] cmd_byte,
    input  logic [7:0] dst_addr,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    input  logic       in_last,
    output logic       in_ready,
    output logic       out_valid,
    output logic [7:0] out_data,
    input  logic       out_ready,
    output logic       done
);

    localparam int IW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    fld_e            state;
    logic            lat_hdr, lat_addr, lat_trl;
    chk_mode_e       lat_mode;
    logic [7:0]      lat_cmd, lat_dst;
    logic [IW-1:0]   rd_idx;
    logic [CW-1:0]   count;
    logic            full;
    logic [7:0]      pay_byte, chk_val, len_byte;
    logic            accept, load_end, fire, last_field, pay_last, covered;
    logic            done_q;

    assign in_ready   = (state == ST_LOAD) && !full;
    assign accept     = in_valid && in_ready;
    assign load_end   = accept && (in_last || count == CW'(DEPTH - 1));
    assign out_valid  = (state != ST_LOAD);
    assign fire       = out_valid && out_ready;
    assign last_field = (state == ST_TRL) || (state == ST_CHK && !lat_trl);
    assign pay_last   = (rd_idx == IW'(count - CW'(1)));
    assign covered    = (state == ST_ADDR) || (state == ST_LEN) ||
                        (state == ST_CMD)  || (state == ST_PAY);
    assign len_byte   = 8'(count) + 8'd3 + {7'd0, lat_hdr} +
                        {7'd0, lat_addr} + {7'd0, lat_trl};
    assign done       = done_q;

    pkt_payload_buf #(.DEPTH(DEPTH), .W(8)) i_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (fire && last_field),
        .wr_en   (accept),
        .wr_data (in_data),
        .rd_idx  (rd_idx),
        .rd_data (pay_byte),
        .count   (count),
        .full    (full)
    );

    pkt_check_unit #(.POLY(8'h07)) i_chk (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (load_end),
        .en    (fire && covered),
        .mode  (lat_mode),
        .din   (out_data),
        .acc   (chk_val)
    );

    // Field sequencer: latch sideband at payload close, step through fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_LOAD;
            rd_idx   <= '0;
            lat_hdr  <= 1'b0;
            lat_addr <= 1'b0;
            lat_trl  <= 1'b0;
            lat_mode <= CHK_SUM;
            lat_cmd  <= '0;
            lat_dst  <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_LOAD: if (load_end) begin
                    lat_hdr  <= cfg_hdr_en;
                    lat_addr <= cfg_addr_en;
                    lat_trl  <= cfg_trl_en;
                    lat_mode <= chk_mode_e'(cfg_chk_mode);
                    lat_cmd  <= cmd_byte;
                    lat_dst  <= dst_addr;
                    rd_idx   <= '0;
                    state    <= cfg_hdr_en  ? ST_HDR  :
                                cfg_addr_en ? ST_ADDR : ST_LEN;
                end
                ST_HDR:  if (fire) state <= lat_addr ? ST_ADDR : ST_LEN;
                ST_ADDR: if (fire) state <= ST_LEN;
                ST_LEN:  if (fire) state <= ST_CMD;
                ST_CMD:  if (fire) state <= ST_PAY;
                ST_PAY:  if (fire) begin
                    if (pay_last) state  <= ST_CHK;
                    else          rd_idx <= rd_idx + IW'(1);
                end
                ST_CHK:  if (fire) begin
                    if (lat_trl) begin
                        state <= ST_TRL;
                    end else begin
                        state  <= ST_LOAD;
                        done_q <= 1'b1;
                    end
                end
                ST_TRL:  if (fire) begin
                    state  <= ST_LOAD;
                    done_q <= 1'b1;
                end
                default: state <= ST_LOAD;
            endcase
        end
    end

    // Select the byte for the current field.
    always_comb begin
        case (state)
            ST_HDR:  out_data = START_MARK;
            ST_ADDR: out_data = lat_dst;
            ST_LEN:  out_data = len_byte;
            ST_CMD:  out_data = lat_cmd;
            ST_PAY:  out_data = pay_byte;
            ST_CHK:  out_data = chk_val;
            ST_TRL:  out_data = END_MARK;
            default: out_data = 8'h00;
        endcase
    end

    // R8
    no_load_while_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid));

    // R9
    hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R10
    done_after_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(fire) && !out_valid));

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: tb/test_pkt_framer.sv
module test_pkt_framer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_hdr_en = 1'b0, cfg_addr_en = 1'b0, cfg_trl_en = 1'b0;
    logic [1:0] cfg_chk_mode = 2'd0;
    logic [7:0] cmd_byte = 8'h00, dst_addr = 8'h00;
    logic       in_valid = 1'b0, in_last = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_ready, out_valid, done;
    logic [7:0] out_data;
    logic       out_ready = 1'b0;

    int errors = 0;
    int checks = 0;

    logic [7:0] exp_b [48];
    string      exp_r [48];
    int         exp_n;
    logic [7:0] got_b [64];
    int         got_n;

    always #10 clk = ~clk;

    pkt_framer i_pkt_framer (
        .clk(clk), .rst_n(rst_n),
        .cfg_hdr_en(cfg_hdr_en), .cfg_addr_en(cfg_addr_en), .cfg_trl_en(cfg_trl_en),
        .cfg_chk_mode(cfg_chk_mode), .cmd_byte(cmd_byte), .dst_addr(dst_addr),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready), .done(done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
        end
    endtask

    function automatic logic [7:0] fold(input logic [7:0] acc, input logic [7:0] d,
                                        input int mode);
        logic [7:0] c;
        if (mode == 1) return acc ^ d;
        if (mode == 2) begin
            c = acc ^ d;
            for (int b = 0; b < 8; b++) c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
            return c;
        end
        return acc + d;
    endfunction

    function automatic logic [7:0] pay_val(input int base, input int i);
        return 8'((base + i * 37) & 255);
    endfunction

    // Build the expected frame from the requirements.
    task automatic build_exp(input bit h, input bit a, input bit t, input int mode,
                             input logic [7:0] cmd, input logic [7:0] dst,
                             input int n, input int base);
        logic [7:0] acc = 8'h00;
        logic [7:0] len = 8'(n + 3 + int'(h) + int'(a) + int'(t));
        exp_n = 0;
        if (h) begin exp_b[exp_n] = 8'hA5; exp_r[exp_n] = "R2 start marker"; exp_n++; end
        if (a) begin
            exp_b[exp_n] = dst; exp_r[exp_n] = "R3 address"; exp_n++;
            acc = fold(acc, dst, mode);
        end
        exp_b[exp_n] = len; exp_r[exp_n] = "R5 length"; exp_n++;
        acc = fold(acc, len, mode);
        exp_b[exp_n] = cmd; exp_r[exp_n] = "R1 command"; exp_n++;
        acc = fold(acc, cmd, mode);
        for (int i = 0; i < n; i++) begin
            exp_b[exp_n] = pay_val(base, i); exp_r[exp_n] = "R1 payload"; exp_n++;
            acc = fold(acc, pay_val(base, i), mode);
        end
        exp_b[exp_n] = acc; exp_r[exp_n] = "R6 check byte"; exp_n++;
        if (t) begin exp_b[exp_n] = 8'h5A; exp_r[exp_n] = "R4 end marker"; exp_n++; end
    endtask

    // Load a payload, scramble the sideband, collect and compare the frame.
    task automatic run_frame(input string name, input bit h, input bit a, input bit t,
                             input int mode, input logic [7:0] cmd, input logic [7:0] dst,
                             input int n, input int base, input bit stall, input bit no_last);
        int  cyc = 0;
        int  last_fire = -10;
        bit  hold = 1'b0;
        logic [7:0] hold_d = 8'h00;
        bit  seen_done = 1'b0;
        build_exp(h, a, t, mode, cmd, dst, n, base);
        got_n = 0;
        cfg_hdr_en = h; cfg_addr_en = a; cfg_trl_en = t;
        cfg_chk_mode = 2'(mode); cmd_byte = cmd; dst_addr = dst;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = pay_val(base, i);
            in_last  = (i == n - 1) && !no_last;
            // R8: payload is taken while loading, nothing is emitted yet
            chk(in_ready && !out_valid, "R8 ready while loading", int'(in_ready), 1);
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        // R8 / R7: input closed once the payload ended
        chk(!in_ready, no_last ? "R7 full store closes payload" : "R8 input closed",
            int'(in_ready), 0);
        // R11: later sideband changes must not reach this frame
        cfg_hdr_en = !h; cfg_addr_en = !a; cfg_trl_en = !t;
        cfg_chk_mode = 2'(mode + 1); cmd_byte = ~cmd; dst_addr = ~dst;
        while (!seen_done && cyc < 300) begin
            out_ready = stall ? (cyc % 3 != 0) : 1'b1;
            if (done) begin
                seen_done = 1'b1;
                // R10: done right after the final accepted byte
                chk(last_fire == cyc - 1, "R10 done timing", cyc - last_fire, 1);
                chk(in_ready && !out_valid, "R10 input reopens with done",
                    int'(in_ready), 1);
            end else begin
                if (hold) begin
                    // R9: held byte under back-pressure
                    chk(out_valid && out_data == hold_d, "R9 stall hold",
                        int'(out_data), int'(hold_d));
                end
                if (out_valid && out_ready) begin
                    if (got_n < 64) got_b[got_n] = out_data;
                    got_n++;
                    last_fire = cyc;
                end
                hold   = out_valid && !out_ready;
                hold_d = out_data;
                @(posedge clk);
                @(negedge clk);
                cyc++;
            end
        end
        chk(seen_done, "R10 done seen", int'(seen_done), 1);
        @(posedge clk);
        @(negedge clk);
        chk(!done, "R10 done single cycle", int'(done), 0);
        // R5: total frame size
        chk(got_n == exp_n, "R5 frame size", got_n, exp_n);
        for (int i = 0; i < exp_n && i < got_n; i++) begin
            // R11: bytes reflect the sideband sampled at payload close
            chk(got_b[i] == exp_b[i], exp_r[i], int'(got_b[i]), int'(exp_b[i]));
        end
        $display("scenario %s done", name);
    endtask

    task automatic t_reset();
        @(negedge clk);
        // R12: idle state after reset
        chk(!out_valid, "R12 out_valid after reset", int'(out_valid), 0);
        chk(!done, "R12 done after reset", int'(done), 0);
        chk(in_ready, "R12 in_ready after reset", int'(in_ready), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        run_frame("all_fields_sum", 1, 1, 1, 0, 8'h31, 8'h12, 5, 10, 0, 0);
        run_frame("bare_xor_stall", 0, 0, 0, 1, 8'hC3, 8'h77, 4, 200, 1, 0);
        run_frame("addr_crc_stall", 0, 1, 0, 2, 8'h5E, 8'h9B, 7, 3, 1, 0);
        run_frame("markers_mode3", 1, 0, 1, 3, 8'hF0, 8'h01, 3, 250, 0, 0);
        run_frame("full_store_crc", 1, 1, 1, 2, 8'h44, 8'h2C, 32, 91, 1, 1);
        run_frame("single_byte_crc", 0, 1, 1, 2, 8'h00, 8'hFF, 1, 128, 0, 0);
        run_frame("sum_wrap", 0, 0, 1, 0, 8'hFF, 8'h00, 6, 240, 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule